// File: doc/BRIEF.md
# Bulk receive frame splitter

This block sits behind a USB bulk-in endpoint of an Ethernet adapter and turns the byte stream of one bulk transfer into separate Ethernet frames. The stream arrives one byte per handshake on a valid/ready input. The final byte of a transfer carries a transfer-end marker. Inside a transfer, every frame is led by a 32-bit status word sent least significant byte first. That word carries the frame's byte length and a flag for a bad frame. After each frame, filler bytes bring the next status word to an offset that is a multiple of four, counted from the first byte of the transfer.

The splitter decodes each status word and forwards the frame bytes on a byte-wide valid/ready output with start and end markers. A drop marker on the final byte tells the consumer to throw the frame away. The padding is consumed without being forwarded. Three malformed cases give one-cycle error strobes, and the rest of the transfer is then ignored: a transfer that ends inside a status word, a frame whose length runs past the end of the transfer, and a transfer longer than the byte limit. A stalled consumer stalls the input only while frame bytes are flowing. The block holds one output byte and does no further buffering.

Top module: `rx_frame_splitter`

## Requirements
- R1: After reset, `out_valid` and all three error strobes are low and `in_ready` is high.
- R2: The status word is assembled little-endian from four accepted bytes. Its bits 29:16 give the frame length N. Exactly N following bytes are forwarded unchanged and in order. Bits 31:30 and 14:0 other than bit 15 have no effect.
- R3: `out_first` is high on the first forwarded byte of each frame and `out_last` on its final byte. Neither marker appears on any other byte.
- R4: When status bit 15 is set, the frame is still forwarded and `out_drop` is high together with `out_last` on its final byte. When bit 15 is clear, `out_drop` stays low for that frame.
- R5: After a frame, the bytes up to the next transfer offset that is a multiple of 4 are consumed and not forwarded. The next status word begins at that offset.
- R6: A status word with length 0 forwards nothing, and the next status word follows at once.
- R7: If the transfer-end marker comes on the first, second or third byte of a status word, `err_short_hdr` pulses for one cycle after that byte is accepted and no frame byte is forwarded.
- R8: If the transfer ends before N frame bytes have arrived, `err_oversize` pulses for one cycle. The byte that carries the transfer end is forwarded with `out_last` and `out_drop` high. If the end comes on the fourth status byte with N > 0, nothing is forwarded.
- R9: Byte number MAX_XFER+1 (2049 by default) of a transfer pulses `err_overrun`. If that byte falls inside a frame, it is forwarded with `out_last` and `out_drop` high. All later bytes up to the transfer end are consumed and ignored.
- R10: Accepting a byte with the transfer-end marker clears the offset. The next byte is treated as the first byte of a status word at offset 0.
- R11: While `out_valid` is high and `out_ready` is low, the output byte and its markers hold. `in_ready` is low during frame bytes while the output register is full, so no byte is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte taken on this edge when valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the final byte of the transfer |
| out_valid | output | 1 | Output frame byte present |
| out_ready | input | 1 | Consumer takes the output byte |
| out_data | output | 8 | Frame byte |
| out_first | output | 1 | First byte of a frame |
| out_last | output | 1 | Final byte of a frame |
| out_drop | output | 1 | Frame is to be discarded (valid with out_last) |
| err_short_hdr | output | 1 | One-cycle strobe: transfer ended inside a status word |
| err_oversize | output | 1 | One-cycle strobe: frame length ran past transfer end |
| err_overrun | output | 1 | One-cycle strobe: transfer exceeded the byte limit |

## Verification
The assertions assume that the producer keeps `in_valid` and its byte steady only in the sense that a byte counts when `in_valid` and `in_ready` are both high at an edge, and that every transfer is closed by a byte carrying `in_last`. They also assume that the consumer may drop `out_ready` at any time. The bench drives bytes only from tasks that raise `in_valid` for whole cycles and always mark the last byte of each transfer. Between bytes it inserts random idle gaps, and it toggles `out_ready` at random with a chosen acceptance rate. Transfers stay within the byte limit except for one directed overrun case, so the framing checks see every frame closed by an end marker or by a drop.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_PAY  = 2'd1,
        ST_PAD  = 2'd2,
        ST_DISC = 2'd3
    } sfs_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       first;
        logic       last;
        logic       drop;
    } sfs_beat_t;

    localparam int unsigned STATUS_BYTES = 4;

endpackage

// File: rtl/sfs_status_decode.sv
module sfs_status_decode #(
    parameter int unsigned LEN_W   = 14,
    parameter int unsigned LEN_LSB = 16,
    parameter int unsigned BAD_BIT = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [1:0]       idx,
    input  logic [7:0]       byte_in,
    output logic [LEN_W-1:0] frame_len,
    output logic             frame_bad
);
    localparam int unsigned HELD   = sfs_pkg::STATUS_BYTES - 1;
    localparam int unsigned WORD_W = 8 * sfs_pkg::STATUS_BYTES;

    logic [HELD-1:0][7:0] held_d, held_q;
    logic [WORD_W-1:0]    stat_word_partly_unused;

    // The first three bytes are held; the fourth is used as it arrives.
    for (genvar g = 0; g < HELD; g++) begin : g_slot
        always_comb begin
            held_d[g] = held_q[g];
            if (capture && (idx == 2'(g))) begin
                held_d[g] = byte_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else begin
            held_q <= held_d;
        end
    end

    assign stat_word_partly_unused = {byte_in, held_q};
    assign frame_len = stat_word_partly_unused[LEN_LSB +: LEN_W];
    assign frame_bad = stat_word_partly_unused[BAD_BIT];

endmodule

// File: rtl/sfs_offset_tracker.sv
module sfs_offset_tracker #(
    parameter int unsigned MAX_XFER = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic clear,
    output logic over_limit,
    output logic word_end
);
    localparam int unsigned OFF_W = $clog2(MAX_XFER + 1);

    logic [OFF_W-1:0] off_d, off_q;

    always_comb begin
        off_d = off_q;
        if (clear) begin
            off_d = '0;
        end else if (step && !over_limit) begin
            off_d = off_q + OFF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
        end else begin
            off_q <= off_d;
        end
    end

    // over_limit: the byte now offered would be beyond the allowed size.
    assign over_limit = (off_q == OFF_W'(MAX_XFER));
    // word_end: the byte now offered is the last of a 4-byte group.
    assign word_end   = (off_q[1:0] == 2'b11);

endmodule

// File: rtl/sfs_out_stage.sv
module sfs_out_stage (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  sfs_pkg::sfs_beat_t beat_in,
    input  logic              out_ready,
    output logic              out_valid,
    output sfs_pkg::sfs_beat_t beat_out,
    output logic              slot_free
);
    typedef struct packed {
        logic               valid;
        sfs_pkg::sfs_beat_t beat;
    } stage_t;

    stage_t st_d, st_q;

    assign slot_free = !st_q.valid || out_ready;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.valid = 1'b1;
            st_d.beat  = beat_in;
        end else if (out_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign beat_out  = st_q.beat;

endmodule

// File: rtl/rx_frame_splitter.sv
module rx_frame_splitter #(
    parameter int unsigned MAX_XFER = 2048,
    parameter int unsigned LEN_W    = 14,
    parameter int unsigned LEN_LSB  = 16,
    parameter int unsigned BAD_BIT  = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_first,
    output logic       out_last,
    output logic       out_drop,
    output logic       err_short_hdr,
    output logic       err_oversize,
    output logic       err_overrun
);
    import sfs_pkg::*;

    localparam logic [1:0] HDR_LAST = 2'(STATUS_BYTES - 1);

    typedef struct packed {
        sfs_state_e       st;
        logic [1:0]       hcnt;
        logic [LEN_W-1:0] rem;
        logic             bad;
        logic             first;
        logic             e_short;
        logic             e_size;
        logic             e_ovr;
    } ctl_t;

    ctl_t       cur_q, nxt_d;
    logic       acc;
    logic       slot_free;
    logic       over_limit;
    logic       word_end;
    logic [LEN_W-1:0] frame_len;
    logic       frame_bad;
    logic       push;
    sfs_beat_t  beat_new;
    sfs_beat_t  beat_out;

    assign in_ready = (cur_q.st == ST_PAY) ? slot_free : 1'b1;
    assign acc      = in_valid && in_ready;

    sfs_status_decode #(
        .LEN_W   (LEN_W),
        .LEN_LSB (LEN_LSB),
        .BAD_BIT (BAD_BIT)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (acc && (cur_q.st == ST_HDR)),
        .idx       (cur_q.hcnt),
        .byte_in   (in_data),
        .frame_len (frame_len),
        .frame_bad (frame_bad)
    );

    sfs_offset_tracker #(
        .MAX_XFER (MAX_XFER)
    ) u_offset (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (acc),
        .clear      (acc && in_last),
        .over_limit (over_limit),
        .word_end   (word_end)
    );

    sfs_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .beat_in   (beat_new),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .beat_out  (beat_out),
        .slot_free (slot_free)
    );

    always_comb begin
        nxt_d         = cur_q;
        nxt_d.e_short = 1'b0;
        nxt_d.e_size  = 1'b0;
        nxt_d.e_ovr   = 1'b0;
        push          = 1'b0;
        beat_new      = '0;
        beat_new.data = in_data;

        unique case (cur_q.st)
            ST_HDR: begin
                if (acc) begin
                    if (over_limit) begin
                        nxt_d.e_ovr = 1'b1;
                        nxt_d.hcnt  = '0;
                        nxt_d.st    = in_last ? ST_HDR : ST_DISC;
                    end else if (cur_q.hcnt != HDR_LAST) begin
                        if (in_last) begin
                            nxt_d.e_short = 1'b1;
                            nxt_d.hcnt    = '0;
                        end else begin
                            nxt_d.hcnt = cur_q.hcnt + 2'd1;
                        end
                    end else begin
                        nxt_d.hcnt = '0;
                        if (frame_len != '0) begin
                            if (in_last) begin
                                nxt_d.e_size = 1'b1;
                            end else begin
                                nxt_d.st    = ST_PAY;
                                nxt_d.rem   = frame_len;
                                nxt_d.bad   = frame_bad;
                                nxt_d.first = 1'b1;
                            end
                        end
                    end
                end
            end

            ST_PAY: begin
                if (acc) begin
                    push           = 1'b1;
                    beat_new.first = cur_q.first;
                    nxt_d.first    = 1'b0;
                    nxt_d.rem      = cur_q.rem - LEN_W'(1);
                    if (over_limit) begin
                        beat_new.last = 1'b1;
                        beat_new.drop = 1'b1;
                        nxt_d.e_ovr   = 1'b1;
                        nxt_d.st      = in_last ? ST_HDR : ST_DISC;
                    end else if (cur_q.rem == LEN_W'(1)) begin
                        beat_new.last = 1'b1;
                        beat_new.drop = cur_q.bad;
                        nxt_d.st      = (in_last || word_end) ? ST_HDR : ST_PAD;
                    end else if (in_last) begin
                        beat_new.last = 1'b1;
                        beat_new.drop = 1'b1;
                        nxt_d.e_size  = 1'b1;
                        nxt_d.st      = ST_HDR;
                    end
                end
            end

            ST_PAD: begin
                if (acc) begin
                    if (over_limit) begin
                        nxt_d.e_ovr = 1'b1;
                        nxt_d.st    = in_last ? ST_HDR : ST_DISC;
                    end else if (in_last || word_end) begin
                        nxt_d.st = ST_HDR;
                    end
                end
            end

            ST_DISC: begin
                if (acc && in_last) begin
                    nxt_d.st = ST_HDR;
                end
            end

            default: nxt_d.st = ST_HDR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q    <= '0;
            cur_q.st <= ST_HDR;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign out_data      = beat_out.data;
    assign out_first     = beat_out.first;
    assign out_last      = beat_out.last;
    assign out_drop      = beat_out.drop;
    assign err_short_hdr = cur_q.e_short;
    assign err_oversize  = cur_q.e_size;
    assign err_overrun   = cur_q.e_ovr;

endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
    parameter int unsigned MAX_XFER = 2048
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       in_last,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_first,
    input logic       out_last,
    input logic       out_drop,
    input logic       err_short_hdr,
    input logic       err_oversize,
    input logic       err_overrun
);
    localparam int unsigned CNT_W = $clog2(MAX_XFER + 2);

    logic             in_frame_q;
    logic [CNT_W-1:0] cnt_q;
    logic             take;

    assign take = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
            cnt_q      <= '0;
        end else begin
            if (out_valid && out_ready) begin
                in_frame_q <= !out_last;
            end
            if (take && in_last) begin
                cnt_q <= '0;
            end else if (take && (cnt_q != CNT_W'(MAX_XFER + 1))) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
            $stable(out_first) && $stable(out_last) && $stable(out_drop)));

    assert_drop_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_drop) |-> out_last);

    assert_first_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_first) |-> !in_frame_q);

    assert_inner_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_first) |-> in_frame_q);

    assert_short_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_short_hdr |-> $past(take && in_last));

    assert_oversize_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_oversize |-> $past(take && in_last));

    assert_overrun_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun |-> $past(take && (cnt_q == CNT_W'(MAX_XFER))));

    assert_one_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_short_hdr, err_oversize, err_overrun}));

endmodule

bind rx_frame_splitter sfs_checker #(
    .MAX_XFER (MAX_XFER)
) u_sfs_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_last       (in_last),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_data      (out_data),
    .out_first     (out_first),
    .out_last      (out_last),
    .out_drop      (out_drop),
    .err_short_hdr (err_short_hdr),
    .err_oversize  (err_oversize),
    .err_overrun   (err_overrun)
);

// File: tb/tb_rx_frame_splitter.sv
`timescale 1ns/1ps
module tb_rx_frame_splitter;
    localparam int MAX_XFER = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;
    logic       out_first, out_last, out_drop;
    logic       err_short_hdr, err_oversize, err_overrun;

    always #2 clk = ~clk;

    rx_frame_splitter #(.MAX_XFER(MAX_XFER)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_first(out_first), .out_last(out_last), .out_drop(out_drop),
        .err_short_hdr(err_short_hdr), .err_oversize(err_oversize), .err_overrun(err_overrun)
    );

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0]  xfer_q[$];
    logic [10:0] exp_q[$];
    logic [10:0] got_q[$];
    int exp_short, exp_size, exp_ovr;
    int got_short = 0, got_size = 0, got_ovr = 0;
    int hold_viol = 0;
    int rdy_pct = 100;
    int gap_max = 0;
    bit finished = 0;
    logic        prev_stall = 1'b0;
    logic [10:0] prev_beat = '0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Sink: samples outputs mid-cycle, then picks out_ready for the next edge.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_stall && !(out_valid && {out_data, out_first, out_last, out_drop} == prev_beat))
                    hold_viol++;
                if (err_short_hdr) got_short++;
                if (err_oversize)  got_size++;
                if (err_overrun)   got_ovr++;
            end
            out_ready = ($urandom_range(99) < rdy_pct);
            #1;
            if (rst_n && out_valid && out_ready)
                got_q.push_back({out_data, out_first, out_last, out_drop});
            prev_stall = out_valid && !out_ready;
            prev_beat  = {out_data, out_first, out_last, out_drop};
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    task automatic send_byte(input logic [7:0] b, input logic lst);
        int gap = (gap_max > 0) ? $urandom_range(gap_max) : 0;
        repeat (gap) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        in_last  = lst;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic add_frame(input int len, input logic bad, input bit pad);
        logic [31:0] w = {2'($urandom), 14'(len), bad, 15'($urandom)};
        for (int i = 0; i < 4; i++) xfer_q.push_back(w[8*i +: 8]);
        for (int i = 0; i < len; i++) xfer_q.push_back(8'($urandom));
        if (pad) while (xfer_q.size() % 4 != 0) xfer_q.push_back(8'($urandom));
    endtask

    // Expected output from the requirements R2..R8.
    task automatic model_xfer();
        int n = xfer_q.size();
        int pos = 0;
        exp_q.delete();
        exp_short = 0; exp_size = 0; exp_ovr = 0;
        while (pos < n) begin
            int len;
            int avail;
            logic bad;
            if (n - pos < 4) begin
                exp_short++;
                break;
            end
            len = {xfer_q[pos+3][5:0], xfer_q[pos+2]};
            bad = xfer_q[pos+1][7];
            pos += 4;
            avail = n - pos;
            if (len > avail) begin
                exp_size++;
                for (int i = 0; i < avail; i++)
                    exp_q.push_back({xfer_q[pos+i], i == 0, i == avail-1, i == avail-1});
                break;
            end
            for (int i = 0; i < len; i++)
                exp_q.push_back({xfer_q[pos+i], i == 0, i == len-1, bad && (i == len-1)});
            pos = ((pos + len + 3) / 4) * 4;
        end
    endtask

    task automatic run_xfer(input string tag);
        int dm = 0, fl = 0, dr = 0, lim;
        for (int i = 0; i < xfer_q.size(); i++) send_byte(xfer_q[i], i == xfer_q.size() - 1);
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        for (int t = 0; t < 20000 && got_q.size() < exp_q.size(); t++) @(negedge clk);
        repeat (4) @(negedge clk);
        lim = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
        for (int i = 0; i < lim; i++) begin
            if (got_q[i][10:3] !== exp_q[i][10:3]) dm++;
            if (got_q[i][2:1]  !== exp_q[i][2:1])  fl++;
            if (got_q[i][0]    !== exp_q[i][0])    dr++;
        end
        chk("R2", {tag, " byte count"}, got_q.size(), exp_q.size());
        chk("R2", {tag, " data mismatches"}, dm, 0);
        chk("R3", {tag, " first/last mismatches"}, fl, 0);
        chk("R4", {tag, " drop mismatches"}, dr, 0);
        chk("R7", {tag, " short header strobes"}, got_short, exp_short);
        chk("R8", {tag, " oversize strobes"}, got_size, exp_size);
        chk("R9", {tag, " overrun strobes"}, got_ovr, exp_ovr);
        got_q.delete();
        xfer_q.delete();
        got_short = 0; got_size = 0; got_ovr = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "out_valid in reset", int'(out_valid), 0);
        chk("R1", "in_ready in reset", int'(in_ready), 1);
        chk("R1", "error strobes in reset", int'({err_short_hdr, err_oversize, err_overrun}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "out_valid after reset", int'(out_valid), 0);
        chk("R1", "in_ready after reset", int'(in_ready), 1);

        // R2 R3 R5: two frames with padding between them
        add_frame(5, 1'b0, 1); add_frame(4, 1'b0, 1);
        model_xfer(); run_xfer("padding R5");
        // R4: bad frame then good frame
        add_frame(3, 1'b1, 1); add_frame(2, 1'b0, 0);
        model_xfer(); run_xfer("bad flag R4");
        // R6: zero-length frames
        add_frame(0, 1'b0, 1); add_frame(6, 1'b0, 1); add_frame(0, 1'b1, 0);
        model_xfer(); run_xfer("zero length R6");
        // R7: transfer ends inside a status word
        add_frame(4, 1'b0, 1); xfer_q.push_back(8'h11); xfer_q.push_back(8'h22);
        model_xfer(); run_xfer("short header R7");
        // R8: length past the end, then end on fourth status byte
        add_frame(20, 1'b0, 0);
        repeat (14) void'(xfer_q.pop_back());
        model_xfer(); run_xfer("truncated frame R8");
        add_frame(10, 1'b0, 0);
        repeat (10) void'(xfer_q.pop_back());
        model_xfer(); run_xfer("header-only R8");

        // R9: overrun inside a frame, byte 2049 closes it with drop
        add_frame(2040, 1'b0, 1); add_frame(100, 1'b0, 0);
        repeat (96) void'(xfer_q.pop_back());
        exp_q.delete();
        for (int i = 0; i < 2040; i++)
            exp_q.push_back({xfer_q[4+i], i == 0, i == 2039, 1'b0});
        exp_q.push_back({xfer_q[2048], 1'b1, 1'b1, 1'b1});
        exp_short = 0; exp_size = 0; exp_ovr = 1;
        run_xfer("overrun R9");
        // R10: the next transfer starts from offset 0
        add_frame(7, 1'b0, 1); add_frame(1, 1'b1, 1);
        model_xfer(); run_xfer("after overrun R10");

        // Random transfers, with backpressure for R11
        for (int x = 0; x < 40; x++) begin
            int nf = $urandom_range(1, 4);
            rdy_pct = (x < 20) ? 25 : 80;
            gap_max = (x % 3 == 0) ? 0 : 2;
            for (int f = 0; f < nf; f++)
                add_frame($urandom_range(0, 60), 1'($urandom_range(3) == 0), 1);
            if ($urandom_range(4) == 0) begin
                int cut = $urandom_range(1, (xfer_q.size() > 8) ? 7 : xfer_q.size() - 1);
                repeat (cut) void'(xfer_q.pop_back());
            end
            model_xfer(); run_xfer("random R10");
        end
        chk("R11", "output changed while stalled", hold_viol, 0);

        finished = 1;
        summary();
        $finish;
    end
endmodule